// File: doc/BRIEF.md
# Write-Back Direct-Mapped L1 Data Cache

This block is a first-level data cache for a processor core with paged virtual memory. It is direct-mapped, holds 16-byte lines, and uses write-back with write-allocate. The line index comes from untranslated page-offset bits of the virtual address. The tag is the 22-bit physical page number, which translation supplies in the same cycle. The lookup therefore runs alongside translation and still behaves as a physically indexed, physically tagged cache.

The core presents one 32-bit load or store at a time. It holds the request stable until `req_ready` is high for one cycle. On a hit, that cycle returns load data or commits the store bytes. On a miss, the cache stalls the core and may write the evicted line back to lower memory. It then reads the new line, merges a pending store into it, and finishes the access in the cycle after the refill. Lower memory has one request channel. A request is held until `mem_done` pulses, and that pulse also carries the refill data.

Top module: `wb_dcache`

## Requirements
- R1: After reset every line is invalid, so the first access to any index is a miss that issues a refill read and no write-back.
- R2: A load that hits raises `req_ready` in the cycle it is presented, with no lower-memory request. `rsp_rdata` carries word `req_vword[1:0]` of the line, where word w is bytes 4w..4w+3 of the 16-byte line.
- R3: A store that hits writes byte b of the selected word only where `req_be[b]` is set (byte b = `req_wdata[8b+7:8b]`). All other bytes of the line keep their value.
- R4: A store hit marks the line dirty. When the line is later evicted, its full current contents are written back to the line's own physical address.
- R5: An access hits only when the line at index `req_vword[9:2]` is valid and its stored tag equals `req_ptag`. The same index with a different tag is a miss, and a different index does not disturb the line.
- R6: A miss whose victim is invalid or clean issues exactly one read at byte address {`req_ptag`, index, 4'b0000} and no write.
- R7: A miss whose victim is valid and dirty first issues a write of the victim line to {victim tag, index, 4'b0000}, and only then the refill read. `mem_wdata` and `mem_rdata` place line byte k on bits [8k+7:8k].
- R8: From the cycle a miss is seen, `req_ready` stays low until the refill read completes. The access then completes in the following cycle.
- R9: A store miss applies its bytes to the refilled line and leaves the line dirty.
- R10: A line refilled for a load is clean, so evicting it later issues no write-back.
- R11: While `mem_valid` is high and `mem_done` is low, `mem_we`, `mem_addr` and `mem_wdata` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Core access request, held until accepted |
| req_we | input | 1 | 1 = store, 0 = load |
| req_be | input | 4 | Byte enables for a store |
| req_vword | input | 10 | Word address within the page (virtual address bits 11:2) |
| req_ptag | input | 22 | Physical page number from translation |
| req_wdata | input | 32 | Store data |
| req_ready | output | 1 | Access completes this cycle |
| rsp_rdata | output | 32 | Load data, valid while `req_ready` is high on a load |
| mem_valid | output | 1 | Lower-memory request pending |
| mem_we | output | 1 | 1 = line write-back, 0 = line read |
| mem_addr | output | 34 | Line-aligned physical byte address |
| mem_wdata | output | 128 | Write-back line data |
| mem_done | input | 1 | Lower memory finishes the pending request |
| mem_rdata | input | 128 | Refill line data, valid with `mem_done` |

## Verification
Corrupted metadata shows up at the memory port on the next access to that index. A lost dirty bit drops a write-back that is owed. A spurious one adds a write-back after a load-only line. A wrong tag turns an expected hit into a read, or sends a write-back to the wrong address. Corrupted line data shows up at `rsp_rdata` on the next load of that word. If the load never comes, it shows up in `mem_wdata` when the line is evicted, where the bench compares it with the contents it predicts from every store so far. A stuck controller state shows up within a cycle as `req_ready` held low, or as an extra or missing request.

// File: rtl/dc_pkg.sv
// Package: shared definitions for the write-back L1 data cache.
// Assumes nothing beyond a single clock domain.
package dc_pkg;
    // Controller states: tag lookup, dirty-victim write-back, line refill
    typedef enum logic [1:0] {
        ST_LOOKUP = 2'd0,
        ST_EVICT  = 2'd1,
        ST_REFILL = 2'd2
    } dc_state_e;

    localparam int unsigned WORD_BYTES = 4;
    localparam int unsigned BYTE_W     = 8;
endpackage

// File: rtl/dc_meta_array.sv
// Module: per-line metadata store (valid, dirty, tag) for a direct-mapped cache.
// Assumes one read index and one write port. The read is combinational.
// Only the valid bits are reset. Dirty and tag bits are meaningful only while valid.
module dc_meta_array #(
    parameter int unsigned IDX_W = 8,
    parameter int unsigned TAG_W = 22
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic             rd_dirty,
    output logic [TAG_W-1:0] rd_tag,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_dirty,
    input  logic [TAG_W-1:0] wr_tag
);
    localparam int unsigned NSETS = 1 << IDX_W;

    logic [NSETS-1:0] valid_q;
    logic [NSETS-1:0] dirty_q;
    logic [TAG_W-1:0] tag_q [NSETS];

    // Valid bits: cleared by reset, set by any metadata write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_idx] <= 1'b1;
        end
    end

    // Dirty and tag bits: written together with the valid bit
    always_ff @(posedge clk) begin
        if (wr_en) begin
            dirty_q[wr_idx] <= wr_dirty;
            tag_q[wr_idx]   <= wr_tag;
        end
    end

    // Combinational read of the addressed entry
    always_comb begin
        rd_valid = valid_q[rd_idx];
        rd_dirty = dirty_q[rd_idx];
        rd_tag   = tag_q[rd_idx];
    end
endmodule

// File: rtl/dc_data_array.sv
// Module: line data store with a byte-masked write port.
// Assumes one combinational read and one write per cycle. Byte k of a line is bits [8k+7:8k].
module dc_data_array #(
    parameter int unsigned IDX_W      = 8,
    parameter int unsigned LINE_BYTES = 16
) (
    input  logic                    clk,
    input  logic [IDX_W-1:0]        rd_idx,
    output logic [LINE_BYTES*8-1:0] rd_line,
    input  logic                    wr_en,
    input  logic [IDX_W-1:0]        wr_idx,
    input  logic [LINE_BYTES-1:0]   wr_bmask,
    input  logic [LINE_BYTES*8-1:0] wr_line
);
    import dc_pkg::*;

    localparam int unsigned NSETS  = 1 << IDX_W;
    localparam int unsigned LINE_W = LINE_BYTES * BYTE_W;

    logic [LINE_W-1:0] line_q [NSETS];

    // Byte-masked write of one line
    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int b = 0; b < LINE_BYTES; b++) begin
                if (wr_bmask[b]) begin
                    line_q[wr_idx][b*BYTE_W +: BYTE_W] <= wr_line[b*BYTE_W +: BYTE_W];
                end
            end
        end
    end

    // Combinational line read
    assign rd_line = line_q[rd_idx];
endmodule

// File: rtl/dc_ctrl.sv
// Module: cache controller. It decides hit or miss, sequences the write-back and the
// refill, and merges store bytes. It assumes the core holds its request stable until
// req_ready, and that lower memory answers each held request with a one-cycle mem_done.
module dc_ctrl #(
    parameter int unsigned TAG_W      = 22,
    parameter int unsigned VOFF_W     = 12,
    parameter int unsigned LINE_BYTES = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req_valid,
    input  logic                         req_we,
    input  logic [3:0]                   req_be,
    input  logic [VOFF_W-3:0]            req_vword,
    input  logic [TAG_W-1:0]             req_ptag,
    input  logic [31:0]                  req_wdata,
    output logic                         req_ready,
    output logic [31:0]                  rsp_rdata,
    output logic [VOFF_W-$clog2(LINE_BYTES)-1:0] arr_idx,
    input  logic                         meta_valid,
    input  logic                         meta_dirty,
    input  logic [TAG_W-1:0]             meta_tag,
    input  logic [LINE_BYTES*8-1:0]      rd_line,
    output logic                         meta_we,
    output logic                         meta_dirty_wr,
    output logic [TAG_W-1:0]             meta_tag_wr,
    output logic                         data_we,
    output logic [LINE_BYTES-1:0]        data_bmask,
    output logic [LINE_BYTES*8-1:0]      data_line,
    output logic                         mem_valid,
    output logic                         mem_we,
    output logic [TAG_W+VOFF_W-1:0]      mem_addr,
    output logic [LINE_BYTES*8-1:0]      mem_wdata,
    input  logic                         mem_done,
    input  logic [LINE_BYTES*8-1:0]      mem_rdata
);
    import dc_pkg::*;

    localparam int unsigned OFF_W  = $clog2(LINE_BYTES);
    localparam int unsigned IDX_W  = VOFF_W - OFF_W;
    localparam int unsigned WORDS  = LINE_BYTES / WORD_BYTES;
    localparam int unsigned WSEL_W = OFF_W - 2;
    localparam int unsigned LINE_W = LINE_BYTES * BYTE_W;

    dc_state_e               state_q, state_d;
    logic [WSEL_W-1:0]       wsel;
    logic                    hit;
    logic [LINE_BYTES-1:0]   st_mask;
    logic [LINE_W-1:0]       st_line;
    logic [LINE_W-1:0]       fill_line;

    // Field split of the request address
    assign arr_idx = req_vword[VOFF_W-3:WSEL_W];
    assign wsel    = req_vword[WSEL_W-1:0];

    // Tag compare against the physical page number
    assign hit = meta_valid && (meta_tag == req_ptag);

    // Store data replicated over all words, with a byte mask for the selected word
    always_comb begin
        st_line = {WORDS{req_wdata}};
        for (int w = 0; w < WORDS; w++) begin
            for (int b = 0; b < WORD_BYTES; b++) begin
                st_mask[w*WORD_BYTES + b] = (wsel == WSEL_W'(w)) && req_be[b];
            end
        end
    end

    // Refill line with pending store bytes merged in
    always_comb begin
        for (int k = 0; k < LINE_BYTES; k++) begin
            fill_line[k*BYTE_W +: BYTE_W] = (req_we && st_mask[k])
                ? st_line[k*BYTE_W +: BYTE_W]
                : mem_rdata[k*BYTE_W +: BYTE_W];
        end
    end

    // Load data selection from the indexed line
    assign rsp_rdata = rd_line[wsel*32 +: 32];

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_LOOKUP;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and datapath controls per state
    always_comb begin
        state_d       = state_q;
        req_ready     = 1'b0;
        meta_we       = 1'b0;
        meta_dirty_wr = 1'b0;
        meta_tag_wr   = req_ptag;
        data_we       = 1'b0;
        data_bmask    = '0;
        data_line     = st_line;
        mem_valid     = 1'b0;
        mem_we        = 1'b0;
        mem_addr      = {req_ptag, arr_idx, {OFF_W{1'b0}}};
        mem_wdata     = rd_line;
        unique case (state_q)
            ST_LOOKUP: begin
                if (req_valid) begin
                    if (hit) begin
                        req_ready = 1'b1;
                        if (req_we) begin
                            data_we       = 1'b1;
                            data_bmask    = st_mask;
                            meta_we       = 1'b1;
                            meta_dirty_wr = 1'b1;
                        end
                    end else if (meta_valid && meta_dirty) begin
                        state_d = ST_EVICT;
                    end else begin
                        state_d = ST_REFILL;
                    end
                end
            end
            ST_EVICT: begin
                mem_valid = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = {meta_tag, arr_idx, {OFF_W{1'b0}}};
                if (mem_done) begin
                    state_d = ST_REFILL;
                end
            end
            ST_REFILL: begin
                mem_valid = 1'b1;
                if (mem_done) begin
                    data_we       = 1'b1;
                    data_bmask    = '1;
                    data_line     = fill_line;
                    meta_we       = 1'b1;
                    meta_dirty_wr = req_we;
                    state_d       = ST_LOOKUP;
                end
            end
            default: state_d = ST_LOOKUP;
        endcase
    end

    // Index width consistency between the address split and the arrays
    initial begin
        if (IDX_W < 1) $error("dc_ctrl: page offset too small for the line size");
    end
endmodule

// File: rtl/wb_dcache.sv
// Module: top of the write-back, write-allocate, direct-mapped L1 data cache.
// Assumes the index bits lie inside the page offset, so they need no translation,
// and that req_ptag arrives in the same cycle as the request.
module wb_dcache #(
    parameter int unsigned PTAG_W     = 22,
    parameter int unsigned VOFF_W     = 12,
    parameter int unsigned LINE_BYTES = 16,
    localparam int unsigned OFF_W     = $clog2(LINE_BYTES),
    localparam int unsigned IDX_W     = VOFF_W - OFF_W,
    localparam int unsigned PA_W      = PTAG_W + VOFF_W,
    localparam int unsigned LINE_W    = LINE_BYTES * 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_we,
    input  logic [3:0]        req_be,
    input  logic [VOFF_W-3:0] req_vword,
    input  logic [PTAG_W-1:0] req_ptag,
    input  logic [31:0]       req_wdata,
    output logic              req_ready,
    output logic [31:0]       rsp_rdata,
    output logic              mem_valid,
    output logic              mem_we,
    output logic [PA_W-1:0]   mem_addr,
    output logic [LINE_W-1:0] mem_wdata,
    input  logic              mem_done,
    input  logic [LINE_W-1:0] mem_rdata
);
    logic [IDX_W-1:0]      arr_idx;
    logic                  meta_valid, meta_dirty;
    logic [PTAG_W-1:0]     meta_tag;
    logic [LINE_W-1:0]     rd_line;
    logic                  meta_we, meta_dirty_wr;
    logic [PTAG_W-1:0]     meta_tag_wr;
    logic                  data_we;
    logic [LINE_BYTES-1:0] data_bmask;
    logic [LINE_W-1:0]     data_line;

    dc_meta_array #(.IDX_W(IDX_W), .TAG_W(PTAG_W)) u_meta (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (arr_idx),
        .rd_valid (meta_valid),
        .rd_dirty (meta_dirty),
        .rd_tag   (meta_tag),
        .wr_en    (meta_we),
        .wr_idx   (arr_idx),
        .wr_dirty (meta_dirty_wr),
        .wr_tag   (meta_tag_wr)
    );

    dc_data_array #(.IDX_W(IDX_W), .LINE_BYTES(LINE_BYTES)) u_data (
        .clk      (clk),
        .rd_idx   (arr_idx),
        .rd_line  (rd_line),
        .wr_en    (data_we),
        .wr_idx   (arr_idx),
        .wr_bmask (data_bmask),
        .wr_line  (data_line)
    );

    dc_ctrl #(.TAG_W(PTAG_W), .VOFF_W(VOFF_W), .LINE_BYTES(LINE_BYTES)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_we        (req_we),
        .req_be        (req_be),
        .req_vword     (req_vword),
        .req_ptag      (req_ptag),
        .req_wdata     (req_wdata),
        .req_ready     (req_ready),
        .rsp_rdata     (rsp_rdata),
        .arr_idx       (arr_idx),
        .meta_valid    (meta_valid),
        .meta_dirty    (meta_dirty),
        .meta_tag      (meta_tag),
        .rd_line       (rd_line),
        .meta_we       (meta_we),
        .meta_dirty_wr (meta_dirty_wr),
        .meta_tag_wr   (meta_tag_wr),
        .data_we       (data_we),
        .data_bmask    (data_bmask),
        .data_line     (data_line),
        .mem_valid     (mem_valid),
        .mem_we        (mem_we),
        .mem_addr      (mem_addr),
        .mem_wdata     (mem_wdata),
        .mem_done      (mem_done),
        .mem_rdata     (mem_rdata)
    );
endmodule

// File: rtl/dc_checker.sv
// Module: protocol and ordering properties of wb_dcache, attached by bind.
// Assumes the core holds a request until req_ready, as the cache requires.
module dc_checker #(
    parameter int unsigned PTAG_W = 22,
    parameter int unsigned VOFF_W = 12,
    parameter int unsigned OFF_W  = 4,
    parameter int unsigned PA_W   = 34,
    parameter int unsigned LINE_W = 128
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [PTAG_W-1:0] req_ptag,
    input logic              mem_valid,
    input logic              mem_we,
    input logic [PA_W-1:0]   mem_addr,
    input logic [LINE_W-1:0] mem_wdata,
    input logic              mem_done
);
    AST_READY_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> req_valid);                                        // R2
    AST_STALL_DURING_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> !req_ready);                                       // R8
    AST_MEM_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_done) |=> (mem_valid && $stable(mem_we)
            && $stable(mem_addr) && $stable(mem_wdata)));                // R11
    AST_WB_THEN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_we && mem_done) |=> (mem_valid && !mem_we));   // R7
    AST_FILL_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_we) |-> (mem_addr[OFF_W-1:0] == '0
            && mem_addr[PA_W-1:VOFF_W] == req_ptag));                   // R6
    AST_FILL_COMPLETES: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_we && mem_done && req_valid) |=> req_ready);  // R8
endmodule

bind wb_dcache dc_checker #(
    .PTAG_W(PTAG_W), .VOFF_W(VOFF_W), .OFF_W(OFF_W), .PA_W(PA_W), .LINE_W(LINE_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_ptag  (req_ptag),
    .mem_valid (mem_valid),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_done  (mem_done)
);

// File: tb/sim_wb_dcache.sv
`timescale 1ns/1ps
module sim_wb_dcache;
    localparam int PTAG_W = 22;
    localparam int PA_W   = 34;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0, req_we = 1'b0;
    logic [3:0]   req_be = '0;
    logic [9:0]   req_vword = '0;
    logic [21:0]  req_ptag = '0;
    logic [31:0]  req_wdata = '0;
    logic         req_ready;
    logic [31:0]  rsp_rdata;
    logic         mem_valid, mem_we;
    logic [33:0]  mem_addr;
    logic [127:0] mem_wdata;
    logic         mem_done = 1'b0;
    logic [127:0] mem_rdata = '0;

    always #10 clk = ~clk;

    wb_dcache u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
        .req_be(req_be), .req_vword(req_vword), .req_ptag(req_ptag),
        .req_wdata(req_wdata), .req_ready(req_ready), .rsp_rdata(rsp_rdata),
        .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_done(mem_done), .mem_rdata(mem_rdata)
    );

    int n_cmp = 0, n_bad = 0;
    bit finished = 1'b0;

    // Result check with one FAIL line per mismatch
    task automatic chk(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Reference state derived from the requirements
    logic [127:0] gold [logic [29:0]];
    logic [127:0] lmem [logic [29:0]];
    bit           mv [256];
    bit           md [256];
    logic [21:0]  mt [256];

    function automatic logic [127:0] init_line(input logic [29:0] la);
        logic [127:0] l;
        for (int w = 0; w < 4; w++) l[w*32 +: 32] = (32'(la) * 32'h9E3779B1) ^ (32'h1111_0000 * (w + 1));
        return l;
    endfunction
    function automatic logic [127:0] gold_get(input logic [29:0] la);
        return gold.exists(la) ? gold[la] : init_line(la);
    endfunction
    function automatic logic [127:0] lmem_get(input logic [29:0] la);
        return lmem.exists(la) ? lmem[la] : init_line(la);
    endfunction

    // Memory traffic log for the access in progress
    int          n_wb, n_rd;
    string       first_op;
    logic [33:0] wb_addr, rd_addr;

    // Lower-memory responder: two cycles of latency, one-cycle done pulse
    initial begin
        int lat = 0;
        forever begin
            @(negedge clk);
            mem_done = 1'b0;
            if (mem_valid && rst_n) begin
                lat++;
                if (lat == 2) begin
                    lat = 0;
                    if (first_op == "") first_op = mem_we ? "W" : "R";
                    if (mem_we) begin
                        n_wb++;
                        wb_addr = mem_addr;
                        chk(mem_wdata == gold_get(mem_addr[33:4]), "R4", "write-back line",
                            mem_wdata, gold_get(mem_addr[33:4]));
                        lmem[mem_addr[33:4]] = mem_wdata;
                    end else begin
                        n_rd++;
                        rd_addr = mem_addr;
                        mem_rdata = lmem_get(mem_addr[33:4]);
                    end
                    mem_done = 1'b1;
                end
            end else begin
                lat = 0;
            end
        end
    end

    // Scoreboard of expected load data
    logic [31:0] exp_q [$];
    string       tag_q [$];

    // Monitor: compares each completed load with the oldest expectation
    initial begin
        forever begin
            @(negedge clk);
            #3;
            if (req_valid && req_ready && !req_we) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R2", "unexpected load data", 128'(rsp_rdata), 128'h0);
                end else begin
                    logic [31:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk(rsp_rdata == e, t, "load data", 128'(rsp_rdata), 128'(e));
                end
            end
        end
    end

    // Driver: one access, with expected traffic predicted from the reference state
    task automatic access(input bit we, input logic [3:0] be, input logic [7:0] idx,
                          input logic [1:0] wd, input logic [21:0] tag,
                          input logic [31:0] wdata, input string dtag);
        logic [29:0]  la;
        logic [127:0] gl;
        bit           hit, need_wb;
        int           stall;
        logic [33:0]  exp_wb, exp_rd;
        la      = {tag, idx};
        hit     = mv[idx] && mt[idx] == tag;
        need_wb = !hit && mv[idx] && md[idx];
        exp_wb  = {mt[idx], idx, 4'h0};
        exp_rd  = {tag, idx, 4'h0};
        gl = gold_get(la);
        if (we) begin
            for (int b = 0; b < 4; b++)
                if (be[b]) gl[wd*32 + b*8 +: 8] = wdata[b*8 +: 8];
            gold[la] = gl;
        end else begin
            exp_q.push_back(gl[wd*32 +: 32]);
            tag_q.push_back(dtag);
        end
        n_wb = 0; n_rd = 0; first_op = "";
        @(negedge clk);
        req_valid = 1'b1; req_we = we; req_be = be;
        req_vword = {idx, wd}; req_ptag = tag; req_wdata = wdata;
        stall = 0;
        forever begin
            #2;
            if (req_ready) break;
            @(negedge clk);
            stall++;
        end
        @(posedge clk);
        #1;
        req_valid = 1'b0;
        chk(n_wb == (need_wb ? 1 : 0), need_wb ? "R7" : (hit ? "R2" : "R10"),
            "write-back count", 128'(n_wb), 128'(need_wb));
        chk(n_rd == (hit ? 0 : 1), hit ? "R5" : "R6", "read count", 128'(n_rd), 128'(!hit));
        chk((stall == 0) == hit, "R8", "stall cycles vs hit", 128'(stall), 128'(!hit));
        if (need_wb) begin
            chk(wb_addr == exp_wb, "R7", "write-back address", 128'(wb_addr), 128'(exp_wb));
            chk(first_op == "W", "R7", "write-back before refill", 128'(first_op == "W"), 128'(1));
        end
        if (!hit) chk(rd_addr == exp_rd, "R6", "refill address", 128'(rd_addr), 128'(exp_rd));
        md[idx] = hit ? (md[idx] | we) : we;
        mv[idx] = 1'b1;
        mt[idx] = tag;
    endtask

    localparam logic [21:0] TA = 22'h0A1B2, TB = 22'h3C4D5, TC = 22'h00001, TD = 22'h3FFFF;

    initial begin
        logic [15:0] lf;
        for (int i = 0; i < 256; i++) begin mv[i] = 1'b0; md[i] = 1'b0; mt[i] = '0; end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(mem_valid == 1'b0 && req_ready == 1'b0, "R1", "idle after reset",
            128'({mem_valid, req_ready}), 128'h0);
        // R1, R6: first access misses with a read only
        access(0, 4'h0, 8'd5, 2'd2, TA, 32'h0, "R1");
        access(0, 4'h0, 8'd5, 2'd1, TA, 32'h0, "R2");
        // R3: partial store on a hit, then read back
        access(1, 4'b0101, 8'd5, 2'd3, TA, 32'hDEAD_BEEF, "R3");
        access(1, 4'b1000, 8'd5, 2'd0, TA, 32'hC0FF_EE11, "R3");
        access(0, 4'h0, 8'd5, 2'd3, TA, 32'h0, "R3");
        access(0, 4'h0, 8'd5, 2'd0, TA, 32'h0, "R3");
        // R5: same index, other tag misses; R4, R7: dirty victim written back first
        access(0, 4'h0, 8'd5, 2'd0, TB, 32'h0, "R5");
        // R10: clean victim evicted with no write-back; stored bytes came back from memory
        access(0, 4'h0, 8'd5, 2'd3, TA, 32'h0, "R4");
        // R5: other index leaves line 5 resident
        access(0, 4'h0, 8'd6, 2'd0, TA, 32'h0, "R5");
        access(0, 4'h0, 8'd5, 2'd2, TA, 32'h0, "R5");
        // R9: store miss merges into the refilled line and leaves it dirty
        access(1, 4'b0010, 8'd255, 2'd1, TC, 32'h1234_5678, "R9");
        access(0, 4'h0, 8'd255, 2'd1, TC, 32'h0, "R9");
        access(0, 4'h0, 8'd255, 2'd1, TD, 32'h0, "R9");
        access(0, 4'h0, 8'd255, 2'd1, TC, 32'h0, "R9");
        // Mixed pattern over a few indices and tags
        lf = 16'hACE1;
        for (int n = 0; n < 300; n++) begin
            logic [21:0] t;
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            case (lf[1:0]) 2'd0: t = TA; 2'd1: t = TB; 2'd2: t = TC; default: t = TD; endcase
            access(lf[2], lf[7:4], {6'd0, lf[9:8]} + 8'd254, lf[11:10], t,
                   {lf, ~lf}, lf[2] ? "R3" : "R2");
        end
        repeat (2) @(negedge clk);
        chk(exp_q.size() == 0, "R2", "pending loads", 128'(exp_q.size()), 128'h0);
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        #(20 * 150000);
        if (!finished) begin
            finished = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL R8 watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule